// File: doc/BRIEF.md
# Logical Device Activation and I/O Conflict-Check Responder

This block keeps the control state of one logical device on a legacy I/O bus. That state is an enable flag that puts the device on the bus, a conflict-check mode with a signature select, and a set of 16-bit I/O base registers. Host configuration software reaches all of it through a byte-wide indexed register port. Each index names one byte.

The block also watches host I/O cycles against every programmed base. Each base covers a window of `RANGE_LEN` consecutive addresses. While the device is enabled, any read or write that falls inside a window raises a decode-hit flag in the same cycle. While the device is disabled and conflict checking is switched on, a read inside a window makes the block drive a fixed signature byte. Software reads that byte back before it enables the device. A signature that arrives corrupted shows that another agent already answers at that address.

A device-level reset input clears every register in the block. It acts like the global configuration reset.

Top module: `ldev_iochk`

## Requirements
- R1: After `rst_n` is released, every index reads 0x00, `io_oe` is 0 and `dec_hit` is 0.
- R2: Index 0x30 holds the enable flag in bit 0. A write stores only bit 0, and bits [7:1] always read as 0 (writing 0xFF reads back 0x01).
- R3: Index 0x31 holds the check-enable flag in bit 1 and the signature select in bit 0. Bits [7:2] always read as 0 (writing 0xFF reads back 0x03).
- R4: Range k (0 to `NUM_RANGES`-1) keeps its base address high byte at index 0x60+2k and its low byte at index 0x61+2k. Each byte reads back as written and leaves every other range untouched.
- R5: A range whose base is 0x0000 never matches any address, 0x0000 included.
- R6: An address A matches range k when base_k ≤ A ≤ base_k + `RANGE_LEN` − 1. The addresses base_k − 1 and base_k + `RANGE_LEN` do not match.
- R7: With the enable flag set, `dec_hit` is 1 in the same cycle as an `io_rd` or `io_wr` to a matching address, and 0 otherwise. `io_oe` stays 0 even when check-enable is set.
- R8: With the enable flag clear and check-enable set, an `io_rd` to a matching address raises `io_oe` in the same cycle and drives `io_rdata` to 0x55 when the signature select is 1, or to 0xAA when it is 0.
- R9: `io_oe` stays 0, and `io_rdata` reads 0x00, for writes, for non-matching reads, and whenever check-enable is clear.
- R10: A one-cycle `dev_rst` pulse returns the enable flag, the check register and all base registers to 0.
- R11: Writes to indices outside 0x30, 0x31 and 0x60 to 0x60+2·`NUM_RANGES`−1 change nothing, and those indices read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_rst | input | 1 | Synchronous device-level reset that clears all registers |
| cfg_wr | input | 1 | Register write strobe, one cycle per byte |
| cfg_idx | input | 8 | Register index |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data for the register at `cfg_idx` (combinational) |
| io_rd | input | 1 | Host I/O read strobe |
| io_wr | input | 1 | Host I/O write strobe |
| io_addr | input | ADDR_W | Host I/O address |
| io_rdata | output | 8 | Signature byte driven during a conflict-check read |
| io_oe | output | 1 | Data-enable for `io_rdata` |
| dec_hit | output | 1 | Enabled device decodes the current cycle |

## Verification
The bench builds the block with all eight ranges and a window of eight addresses. With eight ranges the last base pair at indices 0x6E/0x6F can be reached, and index 0x70 becomes the first unmapped index past the table. With an eight-address window both edges of the window can be probed directly: base−1, base, base+7 and base+8. A zero base is probed at address 0x0000, where a naive subtract-and-compare would falsely match.

// File: rtl/ldev_iochk_pkg.sv
package ldev_iochk_pkg;
   localparam logic [7:0] IDX_ENABLE = 8'h30;
   localparam logic [7:0] IDX_CHECK  = 8'h31;
   localparam logic [7:0] IDX_BASE0  = 8'h60;
   localparam logic [7:0] SIG_SEL1   = 8'h55;
   localparam logic [7:0] SIG_SEL0   = 8'hAA;

   typedef struct packed {
      logic enable;
      logic chk_en;
      logic chk_sel;
   } ctl_t;
endpackage

// File: rtl/ldev_iochk_regs.sv
module ldev_iochk_regs
   import ldev_iochk_pkg::*;
#(
   parameter int NUM_RANGES = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         dev_rst,
   input  logic                         cfg_wr,
   input  logic [7:0]                   cfg_idx,
   input  logic [7:0]                   cfg_wdata,
   output logic [7:0]                   cfg_rdata,
   output ctl_t                         ctl_q,
   output logic [NUM_RANGES-1:0][15:0]  base_q
);
   ctl_t ctl_d;

   always_comb begin
      ctl_d = ctl_q;
      if (cfg_wr && cfg_idx == IDX_ENABLE) ctl_d.enable = cfg_wdata[0];
      if (cfg_wr && cfg_idx == IDX_CHECK) begin
         ctl_d.chk_en  = cfg_wdata[1];
         ctl_d.chk_sel = cfg_wdata[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctl_q <= '0;
      else if (dev_rst) ctl_q <= '0;
      else              ctl_q <= ctl_d;
   end

   for (genvar g = 0; g < NUM_RANGES; g++) begin : g_base
      localparam logic [7:0] HI_IDX = IDX_BASE0 + 8'(2 * g);
      localparam logic [7:0] LO_IDX = IDX_BASE0 + 8'(2 * g + 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       base_q[g] <= '0;
         else if (dev_rst) base_q[g] <= '0;
         else if (cfg_wr && cfg_idx == HI_IDX) base_q[g][15:8] <= cfg_wdata;
         else if (cfg_wr && cfg_idx == LO_IDX) base_q[g][7:0]  <= cfg_wdata;
      end
   end

   always_comb begin
      cfg_rdata = 8'h00;
      if (cfg_idx == IDX_ENABLE) cfg_rdata = {7'b0, ctl_q.enable};
      if (cfg_idx == IDX_CHECK)  cfg_rdata = {6'b0, ctl_q.chk_en, ctl_q.chk_sel};
      for (int k = 0; k < NUM_RANGES; k++) begin
         if (cfg_idx == IDX_BASE0 + 8'(2 * k))     cfg_rdata = base_q[k][15:8];
         if (cfg_idx == IDX_BASE0 + 8'(2 * k + 1)) cfg_rdata = base_q[k][7:0];
      end
   end

   // R2: the enable write lands on the next edge
   a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !dev_rst && cfg_idx == IDX_ENABLE) |=> (ctl_q.enable == $past(cfg_wdata[0])));
   // R10: device reset clears control state
   a_r10_devrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rst |=> (ctl_q == '0 && base_q[0] == 16'h0000));
endmodule

// File: rtl/ldev_iochk_match.sv
module ldev_iochk_match #(
   parameter int NUM_RANGES = 8,
   parameter int ADDR_W     = 16,
   parameter int RANGE_LEN  = 8
) (
   input  logic [ADDR_W-1:0]            io_addr,
   input  logic [NUM_RANGES-1:0][15:0]  base_q,
   output logic [NUM_RANGES-1:0]        hit_vec
);
   localparam int SW = ADDR_W + 1;

   for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cmp
      logic [ADDR_W-1:0] b;
      logic              used;
      assign b    = base_q[g][ADDR_W-1:0];
      assign used = (b != '0);
      if (RANGE_LEN == 1) begin : g_eq
         assign hit_vec[g] = used && (io_addr == b);
      end else begin : g_win
         logic [SW-1:0] diff;
         assign diff       = {1'b0, io_addr} - {1'b0, b};
         assign hit_vec[g] = used && (diff < SW'(RANGE_LEN));
      end
   end
endmodule

// File: rtl/ldev_iochk.sv
module ldev_iochk
   import ldev_iochk_pkg::*;
#(
   parameter int NUM_RANGES = 8,
   parameter int ADDR_W     = 16,
   parameter int RANGE_LEN  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dev_rst,
   input  logic              cfg_wr,
   input  logic [7:0]        cfg_idx,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [ADDR_W-1:0] io_addr,
   output logic [7:0]        io_rdata,
   output logic              io_oe,
   output logic              dec_hit
);
   initial begin
      if (NUM_RANGES < 1 || NUM_RANGES > 8)
         $error("NUM_RANGES must lie in 1..8");
      if (ADDR_W < 10 || ADDR_W > 16)
         $error("ADDR_W must lie in 10..16");
      if (RANGE_LEN < 1 || RANGE_LEN >= (1 << ADDR_W))
         $error("RANGE_LEN out of range");
   end

   ctl_t                        ctl_q;
   logic [NUM_RANGES-1:0][15:0] base_q;
   logic [NUM_RANGES-1:0]       hit_vec;
   logic                        any_hit;
   logic                        check_live;

   ldev_iochk_regs #(.NUM_RANGES(NUM_RANGES)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .dev_rst   (dev_rst),
      .cfg_wr    (cfg_wr),
      .cfg_idx   (cfg_idx),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .ctl_q     (ctl_q),
      .base_q    (base_q)
   );

   ldev_iochk_match #(
      .NUM_RANGES (NUM_RANGES),
      .ADDR_W     (ADDR_W),
      .RANGE_LEN  (RANGE_LEN)
   ) u_match (
      .io_addr (io_addr),
      .base_q  (base_q),
      .hit_vec (hit_vec)
   );

   assign any_hit    = |hit_vec;
   assign check_live = !ctl_q.enable && ctl_q.chk_en;
   assign dec_hit    = ctl_q.enable && any_hit && (io_rd || io_wr);
   assign io_oe      = check_live && io_rd && any_hit;
   assign io_rdata   = io_oe ? (ctl_q.chk_sel ? SIG_SEL1 : SIG_SEL0) : 8'h00;

   // R5: an unused (zero) base never produces a match
   a_r5_zero_base_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (base_q[0] == 16'h0000) |-> !hit_vec[0]);
   // R8: a driven byte is always one of the two signatures
   a_r8_sig_value: assert property (@(posedge clk) disable iff (!rst_n)
      io_oe |-> (io_rdata == SIG_SEL1 || io_rdata == SIG_SEL0));
   // R9: no drive without a read strobe
   a_r9_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |-> (!io_oe && io_rdata == 8'h00));
   // R7: decode flag and signature drive never coexist
   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_oe && dec_hit));
   // R3: reserved check bits read as zero
   a_r3_check_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_idx == IDX_CHECK) |-> (cfg_rdata[7:2] == 6'b0));
endmodule

// File: tb/tb_ldev_iochk.sv
module tb_ldev_iochk;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              dev_rst = 1'b0;
   logic              cfg_wr = 1'b0;
   logic [7:0]        cfg_idx = 8'h00;
   logic [7:0]        cfg_wdata = 8'h00;
   logic [7:0]        cfg_rdata;
   logic              io_rd = 1'b0;
   logic              io_wr = 1'b0;
   logic [ADDR_W-1:0] io_addr = '0;
   logic [7:0]        io_rdata;
   logic              io_oe;
   logic              dec_hit;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ldev_iochk #(.NUM_RANGES(8), .ADDR_W(ADDR_W), .RANGE_LEN(8)) dut (
      .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst),
      .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
      .io_rdata(io_rdata), .io_oe(io_oe), .dec_hit(dec_hit)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] idx, input logic [7:0] d);
      @(negedge clk);
      cfg_idx = idx; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] idx, input logic [7:0] exp);
      @(negedge clk);
      cfg_idx = idx;
      #1;
      check(tag, {8'h00, cfg_rdata}, {8'h00, exp});
   endtask

   // probe one host cycle; returns {dec_hit, io_oe, io_rdata}
   task automatic probe(input logic [15:0] a, input logic r, input logic w,
                        output logic [9:0] res);
      @(negedge clk);
      io_addr = a; io_rd = r; io_wr = w;
      #1;
      res = {dec_hit, io_oe, io_rdata};
      @(negedge clk);
      io_rd = 1'b0; io_wr = 1'b0;
   endtask

   task automatic set_base(input int k, input logic [15:0] b);
      wr(8'h60 + 8'(2 * k), b[15:8]);
      wr(8'h61 + 8'(2 * k), b[7:0]);
   endtask

   task automatic t_reset;
      logic [9:0] r;
      rd_chk("R1 enable idx", 8'h30, 8'h00);
      rd_chk("R1 check idx", 8'h31, 8'h00);
      rd_chk("R1 base0 hi", 8'h60, 8'h00);
      probe(16'h0000, 1'b1, 1'b0, r);
      check("R1 outputs idle", {6'b0, r}, 16'h0000);
   endtask

   task automatic t_ctl_regs;
      wr(8'h30, 8'hFF);
      rd_chk("R2 enable rsv zero", 8'h30, 8'h01);
      wr(8'h30, 8'hFE);
      rd_chk("R2 enable cleared", 8'h30, 8'h00);
      wr(8'h31, 8'hFF);
      rd_chk("R3 check rsv zero", 8'h31, 8'h03);
      wr(8'h31, 8'hFD);
      rd_chk("R3 check bit1 clr", 8'h31, 8'h01);
      wr(8'h31, 8'h02);
      wr(8'h32, 8'hFF);
      wr(8'h2F, 8'hFF);
      wr(8'h70, 8'hFF);
      rd_chk("R11 check untouched", 8'h31, 8'h02);
      rd_chk("R11 enable untouched", 8'h30, 8'h00);
      rd_chk("R11 idx32 reads zero", 8'h32, 8'h00);
      rd_chk("R11 idx70 reads zero", 8'h70, 8'h00);
      rd_chk("R11 base7 lo untouched", 8'h6F, 8'h00);
   endtask

   task automatic t_bases;
      for (int k = 0; k < 8; k++) set_base(k, 16'h1000 + 16'(k * 16'h0111));
      for (int k = 0; k < 8; k++) begin
         logic [15:0] e;
         e = 16'h1000 + 16'(k * 16'h0111);
         rd_chk("R4 base hi", 8'h60 + 8'(2 * k), e[15:8]);
         rd_chk("R4 base lo", 8'h61 + 8'(2 * k), e[7:0]);
      end
      wr(8'h6E, 8'h0F);
      rd_chk("R4 base6 lo kept", 8'h6D, 8'h66);
      rd_chk("R4 base7 lo kept", 8'h6F, 8'h77);
      for (int k = 0; k < 8; k++) set_base(k, 16'h0000);
   endtask

   task automatic t_window;
      logic [9:0] r;
      wr(8'h30, 8'h00);
      wr(8'h31, 8'h03);
      set_base(0, 16'h0220);
      probe(16'h021F, 1'b1, 1'b0, r); check("R6 base-1 miss", {6'b0, r}, 16'h0000);
      probe(16'h0220, 1'b1, 1'b0, r); check("R6 base hit", {6'b0, r}, 16'h0155);
      probe(16'h0227, 1'b1, 1'b0, r); check("R6 base+7 hit", {6'b0, r}, 16'h0155);
      probe(16'h0228, 1'b1, 1'b0, r); check("R6 base+8 miss", {6'b0, r}, 16'h0000);
      probe(16'h0000, 1'b1, 1'b0, r); check("R5 zero base addr0", {6'b0, r}, 16'h0000);
      probe(16'h0005, 1'b1, 1'b0, r); check("R5 zero base addr5", {6'b0, r}, 16'h0000);
      set_base(7, 16'h0F00);
      probe(16'h0F03, 1'b1, 1'b0, r); check("R6 last range hit", {6'b0, r}, 16'h0155);
   endtask

   task automatic t_check_resp;
      logic [9:0] r;
      wr(8'h31, 8'h02);
      probe(16'h0223, 1'b1, 1'b0, r); check("R8 sig AA", {6'b0, r}, 16'h01AA);
      wr(8'h31, 8'h03);
      probe(16'h0223, 1'b1, 1'b0, r); check("R8 sig 55", {6'b0, r}, 16'h0155);
      probe(16'h0223, 1'b0, 1'b1, r); check("R9 write no drive", {6'b0, r}, 16'h0000);
      probe(16'h0300, 1'b1, 1'b0, r); check("R9 miss no drive", {6'b0, r}, 16'h0000);
      wr(8'h31, 8'h01);
      probe(16'h0223, 1'b1, 1'b0, r); check("R9 check off", {6'b0, r}, 16'h0000);
   endtask

   task automatic t_active;
      logic [9:0] r;
      wr(8'h31, 8'h03);
      wr(8'h30, 8'h01);
      probe(16'h0221, 1'b1, 1'b0, r); check("R7 read hit", {6'b0, r}, 16'h0200);
      probe(16'h0226, 1'b0, 1'b1, r); check("R7 write hit", {6'b0, r}, 16'h0200);
      probe(16'h0228, 1'b1, 1'b0, r); check("R7 miss", {6'b0, r}, 16'h0000);
      probe(16'h0221, 1'b0, 1'b0, r); check("R7 no strobe", {6'b0, r}, 16'h0000);
   endtask

   task automatic t_devrst;
      logic [9:0] r;
      @(negedge clk);
      dev_rst = 1'b1;
      @(negedge clk);
      dev_rst = 1'b0;
      rd_chk("R10 enable cleared", 8'h30, 8'h00);
      rd_chk("R10 check cleared", 8'h31, 8'h00);
      rd_chk("R10 base0 hi cleared", 8'h60, 8'h00);
      rd_chk("R10 base0 lo cleared", 8'h61, 8'h00);
      rd_chk("R10 base7 hi cleared", 8'h6E, 8'h00);
      wr(8'h31, 8'h03);
      probe(16'h0220, 1'b1, 1'b0, r); check("R10 range gone", {6'b0, r}, 16'h0000);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctl_regs();
      t_bases();
      t_window();
      t_check_resp();
      t_active();
      t_devrst();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule